// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block produces the modulation word for the feedback divider of a fractional-N clock synthesizer. When the sweep is enabled, it sweeps a signed fractional offset up and down in a symmetric triangle around zero. The synthesizer's output frequency therefore wanders by about plus and minus one percent around its nominal value. This spreads the clock's energy and lowers its spectral peaks. The block runs on the 14.31818 MHz reference clock and moves the offset one step on every reference cycle. One full up-and-down sweep takes 358 cycles, which gives a modulation rate of about 40 kHz.

The size of the step depends on the nominal output frequency: 120 MHz (the default), 72 MHz or 48 MHz. The peak offset is one percent of the nominal divide ratio, expressed in a 24-bit fractional field. The step is one unit `h`, rounded from the parameters in the package. The offset only takes odd multiples of `h`. It runs from -179h to +179h in steps of 2h. As a result, zero is never a sweep point, each ramp lasts exactly 179 cycles, and a full period sums to exactly zero. While the sweep is disabled, the offset sits at zero. On enable, the first value is +h and the sweep continues upward.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, and for the cycles after reset until the sweep is enabled, `offset_o` is 0 and `step_stb_o` is 0.
- R2: If `sweep_en_i` is low at a clock edge, `offset_o` is 0 after that edge and stays 0 for as long as the input stays low.
- R3: At the first edge with `sweep_en_i` high after a disabled cycle, `offset_o` becomes +h for the select value present at that edge. The next value is larger.
- R4: While the sweep runs, every update changes `offset_o` by exactly +2h or -2h.
- R5: The sweep turns at +179h and at -179h. The peak value is held for exactly one cycle, so it is neither repeated nor skipped. Over a full period, the maximum offset is +179h and the minimum is -179h.
- R6: Let k be the number of edges since enable, with k = 0 the edge that produced +h, and let t = k mod 358. The offset follows this profile:
  - for t <= 89, the offset is (2t+1)h;
  - for 89 < t <= 268, the offset is (179 - 2(t-89))h;
  - otherwise, the offset is (-179 + 2(t-268))h.

  This gives 179 rising and 179 falling cycles.
- R7: The 2-bit `freq_sel_i` selects h:
  - 2'b00 gives h = 7855 (120 MHz);
  - 2'b01 gives h = 4713 (72 MHz);
  - 2'b10 gives h = 3142 (48 MHz);
  - 2'b11 gives h = 7855 (120 MHz).
- R8: A change of `freq_sel_i` while the sweep runs has no effect on `offset_o`. The new value takes effect at the next start from the disabled state.
- R9: The sum of `offset_o` over any 358 consecutive sweep cycles is exactly 0.
- R10: `step_stb_o` is 1 exactly in the cycles whose `offset_o` value came from a sweep step. Such a value is never 0. The strobe is 0 in the cycles where the offset is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (14.31818 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sweep_en_i | input | 1 | Sweep enable; low forces the offset to zero |
| freq_sel_i | input | 2 | Nominal output frequency select, sampled at sweep start |
| offset_o | output | 24 | Signed two's-complement fractional divider offset |
| step_stb_o | output | 1 | High in cycles whose offset is a fresh sweep step |

## Verification
The sweep is run for two full periods with each of the four select codes. Each value is compared with the closed-form triangle of R6. The step sizes tell the select codes apart, and the two periods show that the profile repeats without drift. Over the first period the bench also sums the offset and finds its maximum and minimum. These catch an asymmetric turn, a repeated peak or a wrong ramp length, even where the individual steps look correct. Directed runs then do the following:
- change the select mid-sweep, to show it is ignored until the next start;
- drop the enable mid-sweep and hold it low;
- assert reset while the sweep runs.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    SEL_F120 = 2'b00,
    SEL_F72  = 2'b01,
    SEL_F48  = 2'b10,
    SEL_DFLT = 2'b11
  } ssc_sel_e;

  // Half step h = round(f_out * 2^frac_bits / (f_ref * spread_den * half_steps)).
  // Peak offset is half_steps * h, i.e. 1/spread_den of the nominal ratio.
  function automatic longint unsigned ssc_half_step(
    input longint unsigned f_out,
    input longint unsigned f_ref,
    input int unsigned     frac_bits,
    input int unsigned     spread_den,
    input int unsigned     half_steps
  );
    longint unsigned num;
    longint unsigned den;
    num = f_out << frac_bits;
    den = f_ref * 64'(spread_den) * 64'(half_steps);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/ssc_step_sel.sv
module ssc_step_sel #(
  parameter int unsigned     OFS_W      = 24,
  parameter int unsigned     FRAC_BITS  = 24,
  parameter int unsigned     SPREAD_DEN = 100,
  parameter int unsigned     HALF_STEPS = 179,
  parameter longint unsigned REF_HZ     = 64'd14318180,
  parameter longint unsigned F_HI_HZ    = 64'd120000000,
  parameter longint unsigned F_MID_HZ   = 64'd72000000,
  parameter longint unsigned F_LO_HZ    = 64'd48000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [1:0]              sel_i,
  output logic signed [OFS_W-1:0] h_now_o,
  output logic signed [OFS_W-1:0] h_hold_o
);

  localparam int unsigned NSEL = 4;
  localparam longint unsigned F_TBL [NSEL] = '{F_HI_HZ, F_MID_HZ, F_LO_HZ, F_HI_HZ};

  logic signed [OFS_W-1:0] h_tbl [NSEL];
  logic signed [OFS_W-1:0] h_d, h_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_tbl
    assign h_tbl[g] = OFS_W'(ssc_pkg::ssc_half_step(F_TBL[g], REF_HZ, FRAC_BITS,
                                                    SPREAD_DEN, HALF_STEPS));
  end

  always_comb begin
    h_now_o = h_tbl[sel_i];
    h_d     = h_q;
    if (load_i) begin
      h_d = h_now_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
    end else begin
      h_q <= h_d;
    end
  end

  assign h_hold_o = h_q;

endmodule

// File: rtl/ssc_dir_ctrl.sv
module ssc_dir_ctrl #(
  parameter int unsigned HALF_STEPS = 179
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adv_i,
  output logic up_o
);

  localparam int unsigned CW = $clog2(HALF_STEPS + 1);
  localparam logic [CW-1:0] FULL  = CW'(HALF_STEPS);
  localparam logic [CW-1:0] FIRST = CW'((HALF_STEPS - 1) / 2);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] rem_d, rem_q;
  logic          up_d, up_q;

  always_comb begin
    rem_d = rem_q;
    up_d  = up_q;
    if (start_i) begin
      rem_d = FIRST;
      up_d  = 1'b1;
    end else if (adv_i) begin
      if (rem_q == ONE) begin
        rem_d = FULL;
        up_d  = ~up_q;
      end else begin
        rem_d = rem_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= FIRST;
      up_q  <= 1'b1;
    end else begin
      rem_q <= rem_d;
      up_q  <= up_d;
    end
  end

  assign up_o = up_q;

  AST_REM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (rem_q >= ONE && rem_q <= FULL)); // R6

  AST_TURN_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && rem_q == ONE) |=> (up_q != $past(up_q))); // R5

endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc #(
  parameter int unsigned OFS_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    start_i,
  input  logic                    up_i,
  input  logic signed [OFS_W-1:0] h_now_i,
  input  logic signed [OFS_W-1:0] h_hold_i,
  output logic signed [OFS_W-1:0] acc_o
);

  logic signed [OFS_W-1:0] acc_d, acc_q, step2;

  always_comb begin
    step2 = h_hold_i <<< 1;
    if (!en_i) begin
      acc_d = '0;
    end else if (start_i) begin
      acc_d = h_now_i;
    end else if (up_i) begin
      acc_d = acc_q + step2;
    end else begin
      acc_d = acc_q - step2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  AST_ZERO_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0)); // R2

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int unsigned     OFS_W      = 24,
  parameter int unsigned     FRAC_BITS  = 24,
  parameter int unsigned     SPREAD_DEN = 100,
  parameter int unsigned     HALF_STEPS = 179,
  parameter longint unsigned REF_HZ     = 64'd14318180,
  parameter longint unsigned F_HI_HZ    = 64'd120000000,
  parameter longint unsigned F_MID_HZ   = 64'd72000000,
  parameter longint unsigned F_LO_HZ    = 64'd48000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sweep_en_i,
  input  logic [1:0]              freq_sel_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    step_stb_o
);

  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0]       rst_sync_q;
  logic                    rst_n;
  logic                    run_d, run_q;
  logic                    stb_d, stb_q;
  logic                    start, adv, up;
  logic signed [OFS_W-1:0] h_now, h_hold;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[SYNC_N-1];

  always_comb begin
    start = sweep_en_i & ~run_q;
    adv   = sweep_en_i & run_q;
    run_d = sweep_en_i;
    stb_d = sweep_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      run_q <= run_d;
      stb_q <= stb_d;
    end
  end

  ssc_step_sel #(
    .OFS_W(OFS_W), .FRAC_BITS(FRAC_BITS), .SPREAD_DEN(SPREAD_DEN),
    .HALF_STEPS(HALF_STEPS), .REF_HZ(REF_HZ), .F_HI_HZ(F_HI_HZ),
    .F_MID_HZ(F_MID_HZ), .F_LO_HZ(F_LO_HZ)
  ) step_sel_i (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(~run_q), .sel_i(freq_sel_i),
    .h_now_o(h_now), .h_hold_o(h_hold)
  );

  ssc_dir_ctrl #(.HALF_STEPS(HALF_STEPS)) dir_ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start), .adv_i(adv), .up_o(up)
  );

  ssc_ramp_acc #(.OFS_W(OFS_W)) ramp_acc_i (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sweep_en_i), .start_i(start),
    .up_i(up), .h_now_i(h_now), .h_hold_i(h_hold), .acc_o(offset_o)
  );

  assign step_stb_o = stb_q;

  AST_START_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n)
    start |=> (int'(offset_o) == int'($past(h_now)))); // R3

  AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_n)
    adv |=> ((int'(offset_o) - int'($past(offset_o)) ==  2 * int'($past(h_hold))) ||
             (int'(offset_o) - int'($past(offset_o)) == -2 * int'($past(h_hold))))); // R4

  AST_PEAK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    (int'(offset_o) <=  int'(HALF_STEPS) * int'(h_hold)) &&
    (int'(offset_o) >= -int'(HALF_STEPS) * int'(h_hold))); // R5

  AST_STEP_STEADY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adv && $past(adv)) |=>
      ((int'(offset_o) - int'($past(offset_o)) ==  int'($past(offset_o)) - int'($past(offset_o, 2))) ||
       (int'(offset_o) - int'($past(offset_o)) == -(int'($past(offset_o)) - int'($past(offset_o, 2)))))); // R8

  AST_STROBE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n)
    step_stb_o == (offset_o != '0)); // R10

endmodule

// File: tb/ssc_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb_top;

  localparam int PERIOD = 358;
  localparam int HALF   = 179;
  localparam int NVEC   = 4;
  // {select, expected h}
  localparam logic [25:0] VEC_TBL [NVEC] = '{
    {2'b00, 24'd7855}, {2'b01, 24'd4713}, {2'b10, 24'd3142}, {2'b11, 24'd7855}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic [1:0]         sel;
  logic signed [23:0] offset;
  logic               stb;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  ssc_profile_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sweep_en_i(en), .freq_sel_i(sel),
    .offset_o(offset), .step_stb_o(stb)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint tri_val(input int k, input longint h);
    int t;
    t = k % PERIOD;
    if (t <= 89)       return longint'(2 * t + 1) * h;
    else if (t <= 268) return longint'(HALF - 2 * (t - 89)) * h;
    else               return longint'(-HALF + 2 * (t - 268)) * h;
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint h, cur, prev, sum, mx, mn;
    rst_n = 1'b0; en = 1'b0; sel = 2'b00;
    repeat (3) tick();
    chk("R1 offset in reset", longint'(offset), 0);
    chk("R1 strobe in reset", longint'(stb), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 offset after reset", longint'(offset), 0);
    chk("R1 strobe after reset", longint'(stb), 0);

    // table-driven sweeps, two full periods per select code
    for (int v = 0; v < NVEC; v++) begin
      sel = VEC_TBL[v][25:24];
      h   = longint'(VEC_TBL[v][23:0]);
      en  = 1'b0;
      tick(); tick();
      chk("R2 idle offset", longint'(offset), 0);
      en = 1'b1;
      prev = 0; sum = 0; mx = -(64'sd1 << 40); mn = (64'sd1 << 40);
      for (int k = 0; k < 2 * PERIOD; k++) begin
        tick();
        cur = longint'(offset);
        if (k == 0) begin
          chk("R3 first value", cur, h);
          chk("R7 select step", cur, h);
        end else begin
          chk("R4 step magnitude", absl(cur - prev), 2 * h);
        end
        chk("R6 triangle profile", cur, tri_val(k, h));
        chk("R10 strobe during sweep", longint'(stb), 1);
        if (k < PERIOD) begin
          sum += cur;
          if (cur > mx) mx = cur;
          if (cur < mn) mn = cur;
        end
        prev = cur;
      end
      chk("R9 period sum", sum, 0);
      chk("R5 max peak", mx, HALF * h);
      chk("R5 min peak", mn, -HALF * h);
      en = 1'b0;
      tick();
      chk("R2 offset after disable", longint'(offset), 0);
      chk("R10 strobe after disable", longint'(stb), 0);
    end

    // R8: select change mid-sweep is ignored until restart
    sel = 2'b00; en = 1'b1;
    for (int k = 0; k < 400; k++) begin
      tick();
      chk("R8 sweep with changed select", longint'(offset), tri_val(k, 7855));
      if (k == 10) sel = 2'b10;
    end
    en = 1'b0; tick();
    en = 1'b1; tick();
    chk("R8 new select at restart", longint'(offset), 3142);
    tick();
    chk("R8 second value after restart", longint'(offset), 3 * 3142);

    // R2: disable mid-sweep and hold low
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R2 held disabled", longint'(offset), 0);
      chk("R10 strobe held disabled", longint'(stb), 0);
    end

    // R1: reset while sweeping
    en = 1'b1;
    repeat (30) tick();
    rst_n = 1'b0;
    #1;
    chk("R1 async reset offset", longint'(offset), 0);
    chk("R1 async reset strobe", longint'(stb), 0);
    en = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 offset after mid-sweep reset", longint'(offset), 0);
    en = 1'b1;
    tick();
    chk("R3 start after reset", longint'(offset), 3142);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule